// File: doc/BRIEF.md
# Lane Writemask Generator

This block turns a compact lane-enable description into one enable bit per lane for a SIMD arithmetic datapath. Each of the two operand sides (X and Y) has a 2-bit mode and a 5-bit value. Together they pick one of four shapes:

- a parity pattern;
- a single lane;
- a run of lanes starting at lane 0;
- a run of lanes ending at the top lane.

A shared element-width select sets how many lanes exist. Wider elements give fewer lanes.

A vector-mode flag switches the datapath to pointwise operation. In that mode the Y description has no meaning, so every active Y lane is enabled. Both masks are registered, so they reach the datapath one clock after the inputs are sampled. They are laid out for the largest lane count, and bits above the active lane count are held at zero.

Top module: `lane_mask_gen`

## Requirements
- R1: Both masks are registered. A change on any input appears on `x_mask`/`y_mask` after the next rising clock edge and not before. While `rst_n` is low, both masks are zero, without waiting for a clock.
- R2: Mode 0 (parity) works as follows. Value 0 enables every active lane. Value 1 enables only the odd-numbered lanes. Value 2 enables only the even-numbered lanes. Any value of 3 or more enables no lane.
- R3: Mode 1 (single) enables only the lane whose index equals the value.
- R4: Mode 2 (leading) with value N enables lanes 0 to N-1.
- R5: Mode 3 (trailing) with value N enables the top N active lanes, that is lanes count-N to count-1.
- R6: In modes 2 and 3, a value of 0 enables every active lane.
- R7: `width_sel` sets the lane count and the number of active lanes. Code 0 selects 64-bit elements with 8 lanes. Code 1 selects 32-bit elements with 16 lanes. Codes 2 and 3 select 16-bit elements with 32 lanes. Bit i of a mask belongs to lane i, and mask bits at or above the lane count are always zero.
- R8: In mode 1, a value at or above the lane count enables no lane.
- R9: In modes 2 and 3, a value at or above the lane count enables every active lane.
- R10: When `vec_mode` is 1, `y_mask` enables every active lane whatever `y_mode` and `y_value` hold.
- R11: `vec_mode` has no effect on `x_mask`, which still follows `x_mode` and `x_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_mode | input | 2 | Mask shape for the X side |
| x_value | input | 5 | Shape parameter for the X side |
| y_mode | input | 2 | Mask shape for the Y side |
| y_value | input | 5 | Shape parameter for the Y side |
| width_sel | input | 2 | Element width: 0 = 64-bit, 1 = 32-bit, 2 or 3 = 16-bit |
| vec_mode | input | 1 | Pointwise mode; forces all Y lanes on |
| x_mask | output | 32 | Per-lane X enables, bit i = lane i |
| y_mask | output | 32 | Per-lane Y enables, bit i = lane i |

## Verification
Every mask result is due exactly one rising edge after its inputs are presented. The bench therefore drives on the falling edge and compares shortly after the following rising edge. A latency check samples just before that edge to confirm that the old mask still holds there. Reset clearing is asynchronous, so it is checked a fraction of a cycle after `rst_n` falls, with no clock edge in between. The checker's properties relate inputs in one cycle to the masks in the next.

// File: rtl/lmg_pkg.sv
package lmg_pkg;

    localparam int LMG_LANES = 32;
    localparam int LMG_VAL_W = 5;
    localparam int LMG_CNT_W = $clog2(LMG_LANES) + 1;

    typedef enum logic [1:0] {
        MM_PARITY = 2'd0,
        MM_SINGLE = 2'd1,
        MM_LEAD   = 2'd2,
        MM_TRAIL  = 2'd3
    } mask_mode_e;

    typedef enum logic [1:0] {
        EW_64 = 2'd0,
        EW_32 = 2'd1,
        EW_16 = 2'd2,
        EW_16B = 2'd3
    } elem_width_e;

    typedef struct packed {
        logic [LMG_LANES-1:0] x_mask;
        logic [LMG_LANES-1:0] y_mask;
    } mask_state_t;

endpackage

// File: rtl/lmg_lane_count.sv
module lmg_lane_count #(
    parameter int LANES = 32,
    parameter int CNT_W = $clog2(LANES) + 1
) (
    input  logic [1:0]       width_sel,
    output logic [CNT_W-1:0] lane_count
);
    localparam logic [CNT_W-1:0] CNT_FULL    = CNT_W'(LANES);
    localparam logic [CNT_W-1:0] CNT_HALF    = CNT_W'(LANES / 2);
    localparam logic [CNT_W-1:0] CNT_QUARTER = CNT_W'(LANES / 4);

    always_comb begin
        case (width_sel)
            2'd0:    lane_count = CNT_QUARTER;
            2'd1:    lane_count = CNT_HALF;
            default: lane_count = CNT_FULL;
        endcase
    end
endmodule

// File: rtl/lmg_mask_core.sv
module lmg_mask_core #(
    parameter int LANES = 32,
    parameter int VAL_W = 5,
    parameter int CNT_W = $clog2(LANES) + 1
) (
    input  logic [1:0]       mode,
    input  logic [VAL_W-1:0] value,
    input  logic [CNT_W-1:0] lane_count,
    input  logic             force_all,
    output logic [LANES-1:0] mask
);
    logic [CNT_W-1:0] val_ext;
    logic             n_covers_all;
    logic [CNT_W-1:0] trail_start;

    always_comb begin
        val_ext      = CNT_W'(value);
        n_covers_all = (val_ext == '0) || (val_ext >= lane_count);
        trail_start  = lane_count - val_ext;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        localparam logic             ODD = (i % 2) == 1;
        logic active;

        always_comb begin
            active = IDX < lane_count;
            if (!active) begin
                mask[i] = 1'b0;
            end else if (force_all) begin
                mask[i] = 1'b1;
            end else begin
                case (mode)
                    2'd0: begin
                        case (value)
                            VAL_W'(0): mask[i] = 1'b1;
                            VAL_W'(1): mask[i] = ODD;
                            VAL_W'(2): mask[i] = !ODD;
                            default:   mask[i] = 1'b0;
                        endcase
                    end
                    2'd1:    mask[i] = (IDX == val_ext);
                    2'd2:    mask[i] = n_covers_all || (IDX < val_ext);
                    default: mask[i] = n_covers_all || (IDX >= trail_start);
                endcase
            end
        end
    end
endmodule

// File: rtl/lane_mask_gen.sv
module lane_mask_gen
    import lmg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           x_mode,
    input  logic [LMG_VAL_W-1:0] x_value,
    input  logic [1:0]           y_mode,
    input  logic [LMG_VAL_W-1:0] y_value,
    input  logic [1:0]           width_sel,
    input  logic                 vec_mode,
    output logic [LMG_LANES-1:0] x_mask,
    output logic [LMG_LANES-1:0] y_mask
);
    localparam int SIDES = 2;

    logic [LMG_CNT_W-1:0] lane_count;
    logic [1:0]           side_mode  [SIDES];
    logic [LMG_VAL_W-1:0] side_value [SIDES];
    logic                 side_force [SIDES];
    logic [LMG_LANES-1:0] side_mask  [SIDES];

    mask_state_t st_d;
    mask_state_t st_q;

    lmg_lane_count #(
        .LANES (LMG_LANES),
        .CNT_W (LMG_CNT_W)
    ) i_count (
        .width_sel  (width_sel),
        .lane_count (lane_count)
    );

    always_comb begin
        side_mode[0]  = x_mode;
        side_value[0] = x_value;
        side_force[0] = 1'b0;
        side_mode[1]  = y_mode;
        side_value[1] = y_value;
        side_force[1] = vec_mode;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        lmg_mask_core #(
            .LANES (LMG_LANES),
            .VAL_W (LMG_VAL_W),
            .CNT_W (LMG_CNT_W)
        ) i_core (
            .mode       (side_mode[s]),
            .value      (side_value[s]),
            .lane_count (lane_count),
            .force_all  (side_force[s]),
            .mask       (side_mask[s])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.x_mask = side_mask[0];
        st_d.y_mask = side_mask[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_mask = st_q.x_mask;
    assign y_mask = st_q.y_mask;
endmodule

// File: rtl/lmg_checker.sv
module lmg_checker
    import lmg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           x_mode,
    input logic [LMG_VAL_W-1:0] x_value,
    input logic [1:0]           y_mode,
    input logic [LMG_VAL_W-1:0] y_value,
    input logic [1:0]           width_sel,
    input logic                 vec_mode,
    input logic [LMG_LANES-1:0] x_mask,
    input logic [LMG_LANES-1:0] y_mask
);
    localparam int Q = LMG_LANES / 4;
    localparam int H = LMG_LANES / 2;

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (width_sel == 2'd0) |=> (x_mask[LMG_LANES-1:Q] == '0 && y_mask[LMG_LANES-1:Q] == '0));

    p_upper_half_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (width_sel == 2'd1) |=> (x_mask[LMG_LANES-1:H] == '0 && y_mask[LMG_LANES-1:H] == '0));

    p_single_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_mode == 2'd1) |=> $onehot0(x_mask));

    p_parity_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (x_mode == 2'd0 && x_value > 5'd2) |=> (x_mask == '0));

    p_vec_y_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_mode && width_sel[1]) |=> (&y_mask));

    p_zero_n_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (x_mode[1] && x_value == '0 && width_sel[1]) |=> (&x_mask));

    p_y_single_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_mode && y_mode == 2'd1) |=> $onehot0(y_mask));
endmodule

bind lane_mask_gen lmg_checker i_chk (.*);

// File: tb/test_lane_mask_gen.sv
`timescale 1ns/1ps
module test_lane_mask_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  x_mode = '0;
    logic [4:0]  x_value = '0;
    logic [1:0]  y_mode = '0;
    logic [4:0]  y_value = '0;
    logic [1:0]  width_sel = '0;
    logic        vec_mode = 1'b0;
    logic [31:0] x_mask;
    logic [31:0] y_mask;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lane_mask_gen i_lane_mask_gen (
        .clk(clk), .rst_n(rst_n),
        .x_mode(x_mode), .x_value(x_value),
        .y_mode(y_mode), .y_value(y_value),
        .width_sel(width_sel), .vec_mode(vec_mode),
        .x_mask(x_mask), .y_mask(y_mask)
    );

    localparam int NV = 14;
    // {x_mode, x_value, y_mode, y_value, width_sel, vec_mode, exp_x, exp_y}
    localparam logic [80:0] VEC [NV] = '{
        {2'd0, 5'd0,  2'd0, 5'd1,  2'd2, 1'b0, 32'hFFFF_FFFF, 32'hAAAA_AAAA}, // R2
        {2'd0, 5'd2,  2'd0, 5'd5,  2'd1, 1'b0, 32'h0000_5555, 32'h0000_0000}, // R2 R7
        {2'd1, 5'd5,  2'd1, 5'd8,  2'd0, 1'b0, 32'h0000_0020, 32'h0000_0000}, // R3 R8
        {2'd1, 5'd31, 2'd1, 5'd16, 2'd2, 1'b0, 32'h8000_0000, 32'h0001_0000}, // R3
        {2'd2, 5'd3,  2'd2, 5'd0,  2'd1, 1'b0, 32'h0000_0007, 32'h0000_FFFF}, // R4 R6
        {2'd2, 5'd16, 2'd2, 5'd20, 2'd1, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF}, // R9
        {2'd3, 5'd3,  2'd3, 5'd0,  2'd0, 1'b0, 32'h0000_00E0, 32'h0000_00FF}, // R5 R6
        {2'd3, 5'd1,  2'd3, 5'd9,  2'd2, 1'b0, 32'h8000_0000, 32'hFF80_0000}, // R5
        {2'd3, 5'd10, 2'd2, 5'd8,  2'd0, 1'b0, 32'h0000_00FF, 32'h0000_00FF}, // R9
        {2'd1, 5'd2,  2'd0, 5'd7,  2'd1, 1'b1, 32'h0000_0004, 32'h0000_FFFF}, // R10 R11
        {2'd2, 5'd2,  2'd1, 5'd3,  2'd0, 1'b1, 32'h0000_0003, 32'h0000_00FF}, // R10 R11
        {2'd0, 5'd1,  2'd2, 5'd31, 2'd3, 1'b0, 32'hAAAA_AAAA, 32'h7FFF_FFFF}, // R7 R4
        {2'd0, 5'd1,  2'd0, 5'd2,  2'd0, 1'b0, 32'h0000_00AA, 32'h0000_0055}, // R7 R2
        {2'd2, 5'd31, 2'd3, 5'd31, 2'd2, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFE}  // R4 R5
    };
    localparam string TAG [NV] = '{"R2", "R2/R7", "R3/R8", "R3", "R4/R6", "R9", "R5/R6",
                                   "R5", "R9", "R10/R11", "R10/R11", "R7", "R7", "R4/R5"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 5000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset x", x_mask, 32'h0);
        check("R1 reset y", y_mask, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            {x_mode, x_value, y_mode, y_value, width_sel, vec_mode} = VEC[k][80:64];
            @(posedge clk);
            #1;
            check({TAG[k], " x"}, x_mask, VEC[k][63:32]);
            check({TAG[k], " y"}, y_mask, VEC[k][31:0]);
        end

        // R1: latency, old value held until the edge
        @(negedge clk);
        {x_mode, x_value, y_mode, y_value, width_sel, vec_mode} =
            {2'd1, 5'd0, 2'd1, 5'd1, 2'd2, 1'b0};
        #2;
        check("R1 before edge x", x_mask, 32'h7FFF_FFFF);
        @(posedge clk);
        #1;
        check("R1 after edge x", x_mask, 32'h0000_0001);
        check("R1 after edge y", y_mask, 32'h0000_0002);

        // R8: single lane just past 16-lane range
        @(negedge clk);
        {x_mode, x_value, width_sel} = {2'd1, 5'd16, 2'd1};
        @(posedge clk);
        #1;
        check("R8 x", x_mask, 32'h0);

        // R1: asynchronous reset clears without an edge
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async x", x_mask, 32'h0);
        check("R1 async y", y_mask, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule